// File: doc/BRIEF.md
# Event State Page MMIO Decoder

This block is a memory-mapped slave that gives software load/store access to the two coalescing state pairs kept in each event descriptor: the notify pair and the escalate pair. Every descriptor owns two adjacent pages of 2^SHIFT bytes. The even page reaches the notify pair and the odd page reaches the escalate pair. The low twelve address bits inside a page select the operation.

An accepted access is decoded into descriptor index, page parity and operation. Malformed accesses are answered at once without touching the descriptor store. Well-formed accesses fetch the descriptor through a simple read port and apply the operation to the selected two-bit state. The changed descriptor is written back through a posted write port only when the state really moved. The block then returns a response and, where the operation calls for it, pulses a notify output that carries the descriptor index. Each pair is encoded as {P, Q}: P is bit 1 (pending) and Q is bit 0 (queued). Only one access is in flight at a time.

Top module: `esp_mmio_decoder`

## Requirements
- R1: While reset is held, and right after it, req_ready is 1 and rsp_valid, ds_rd_req, ds_wr_en and notify_pulse are 0.
- R2: The descriptor index is req_addr >> (SHIFT+1) and is presented on ds_rd_idx. Address bit SHIFT selects the pair: 0 selects the notify pair, descriptor bits [1:0]; 1 selects the escalate pair, bits [3:2]. Descriptor bit 7 is the valid flag.
- R3: A size other than 8 bytes, an index of COUNT or more, or a store at offset 0xC00-0xFFF gets rsp_err=1 one cycle after acceptance, with no store read. rsp_rdata is all ones for a load and 0 for a store.
- R4: A fetch answered with ds_rd_miss=1, or a descriptor whose bit 7 is 0, gives rsp_err=1 with the same data rule as R3, no write-back and no notify.
- R5: A load at offset 0x000-0x7FF performs end-of-interrupt: 11 becomes 10 and returns 1 in rsp_rdata bit 0 with a notify pulse; 10 becomes 00 and returns 0; 00 and 01 stay as they are and return 0.
- R6: A load at offset 0x800-0xBFF returns the selected pair in rsp_rdata[1:0], with the upper bits 0, and changes nothing.
- R7: A load at offset 0xC00-0xFFF sets the pair to address bits [9:8] and returns the old pair in rsp_rdata[1:0].
- R8: A store at offset 0x000-0x3FF triggers: 00 becomes 10 with a notify pulse; 10 and 11 become 11; 01 is unchanged. Store responses carry rsp_rdata=0.
- R9: A store at offset 0x400-0x7FF performs end-of-interrupt with the transitions and notify rule of R5.
- R10: A store at offset 0x800-0xBFF injects: on the notify page it pulses notify and leaves the state unchanged; on the escalate page it is answered with rsp_err=1 and no notify.
- R11: ds_wr_en pulses once, together with rsp_valid, only when the selected pair changed. ds_wr_idx is the access index and ds_wr_data is the fetched word with only the selected pair replaced.
- R12: notify_pulse is high only in the cycle of a non-error response, with notify_idx equal to the access index.
- R13: req_ready is 0 from acceptance of a fetching access until its response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, can accept |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | SHIFT+1+IDX_W | Byte address within the decoded region |
| req_size | input | 4 | Access size in bytes |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 64 | Load result |
| ds_rd_req | output | 1 | Descriptor read request, held until ack |
| ds_rd_idx | output | IDX_W | Descriptor index to read |
| ds_rd_ack | input | 1 | Read data valid |
| ds_rd_miss | input | 1 | Descriptor not present |
| ds_rd_data | input | 8 | Descriptor word |
| ds_wr_en | output | 1 | Posted descriptor write |
| ds_wr_idx | output | IDX_W | Descriptor index to write |
| ds_wr_data | output | 8 | Descriptor word to write |
| notify_pulse | output | 1 | Event to forward to the router |
| notify_idx | output | IDX_W | Descriptor index of the event |

## Verification
A malformed access (R3) is answered in the cycle after the edge that accepts it. A fetching access raises ds_rd_req in that same cycle. Its response, write-back and notify pulse all appear together one cycle after the store's ack, which the bench's store model returns one cycle after the request. The driver checks ds_rd_req, ds_rd_idx and req_ready at the first falling edge after acceptance. The monitor checks every response at the falling edge of the cycle in which rsp_valid is high, and also checks that the number of store reads since the previous response matches whether a fetch was due.

// File: rtl/esp_pkg.sv
package esp_pkg;

  typedef enum logic [2:0] {
    OP_LD_EOI, OP_LD_GET, OP_LD_SET,
    OP_ST_TRIG, OP_ST_EOI, OP_ST_INJ, OP_BAD
  } esp_op_e;

  typedef struct packed {
    logic       live;
    logic [2:0] spare;
    logic [1:0] esc;
    logic [1:0] ntf;
  } esp_desc_t;

  // {fire, next_pq}: pending/queued coalescing on a new event
  function automatic logic [2:0] pq_trigger(input logic [1:0] pq);
    case (pq)
      2'b00:   return {1'b1, 2'b10};
      2'b10,
      2'b11:   return {1'b0, 2'b11};
      default: return {1'b0, pq};
    endcase
  endfunction

  // {retrigger, next_pq}: completion of a pending event
  function automatic logic [2:0] pq_eoi(input logic [1:0] pq);
    case (pq)
      2'b11:   return {1'b1, 2'b10};
      2'b10:   return {1'b0, 2'b00};
      default: return {1'b0, pq};
    endcase
  endfunction

  function automatic esp_op_e op_of(input logic is_store, input logic [1:0] region);
    case ({is_store, region})
      3'b000, 3'b001: return OP_LD_EOI;
      3'b010:         return OP_LD_GET;
      3'b011:         return OP_LD_SET;
      3'b100:         return OP_ST_TRIG;
      3'b101:         return OP_ST_EOI;
      3'b110:         return OP_ST_INJ;
      default:        return OP_BAD;
    endcase
  endfunction

endpackage

// File: rtl/esp_addr_decode.sv
module esp_addr_decode
  import esp_pkg::*;
#(
  parameter int SHIFT  = 16,
  parameter int COUNT  = 8,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_store,
  input  logic [3:0]        size,
  output logic [IDX_W-1:0]  idx,
  output logic              esc_page,
  output esp_op_e           op,
  output logic [1:0]        set_val,
  output logic              bad
);
  logic [ADDR_W-1:0] idx_wide;
  logic              in_range;
  logic              unused_lo;

  assign idx_wide = addr >> (SHIFT + 1);
  assign idx      = idx_wide[IDX_W-1:0];
  assign in_range = idx_wide < ADDR_W'(COUNT);
  assign esc_page = addr[SHIFT];
  assign op       = op_of(is_store, addr[11:10]);
  assign set_val  = addr[9:8];
  assign bad      = (size != 4'd8) || !in_range || (op == OP_BAD);
  assign unused_lo = ^addr[7:0];

  generate
    if (SHIFT > 12) begin : g_mid
      logic unused_mid;
      assign unused_mid = ^addr[SHIFT-1:12];
    end
  endgenerate
endmodule

// File: rtl/esp_state_update.sv
module esp_state_update
  import esp_pkg::*;
(
  input  esp_op_e     op,
  input  logic        esc_page,
  input  logic [1:0]  set_val,
  input  esp_desc_t   desc,
  input  logic        miss,
  output esp_desc_t   new_desc,
  output logic [63:0] rdata,
  output logic        err,
  output logic        notify,
  output logic        changed
);
  logic [1:0] pq, npq;
  logic [2:0] step;
  logic       fire, fault, inj_esc, is_load;
  logic [63:0] res;

  assign pq      = esc_page ? desc.esc : desc.ntf;
  assign fault   = miss || !desc.live;
  assign inj_esc = (op == OP_ST_INJ) && esc_page;
  assign is_load = (op == OP_LD_EOI) || (op == OP_LD_GET) || (op == OP_LD_SET);

  always_comb begin
    step = {1'b0, pq};
    res  = '0;
    case (op)
      OP_LD_EOI: begin step = pq_eoi(pq); res = {63'd0, step[2]}; end
      OP_LD_GET: res = {62'd0, pq};
      OP_LD_SET: begin step = {1'b0, set_val}; res = {62'd0, pq}; end
      OP_ST_TRIG: step = pq_trigger(pq);
      OP_ST_EOI:  step = pq_eoi(pq);
      OP_ST_INJ:  step = {1'b1, pq};
      default:    step = {1'b0, pq};
    endcase
  end

  assign npq  = step[1:0];
  assign fire = step[2];
  assign err  = fault || inj_esc;

  always_comb begin
    new_desc = desc;
    if (esc_page) new_desc.esc = npq;
    else          new_desc.ntf = npq;
  end

  assign notify  = fire && !err;
  assign changed = !err && (npq != pq);
  assign rdata   = err ? (is_load ? '1 : '0) : res;
endmodule

// File: rtl/esp_mmio_decoder.sv
module esp_mmio_decoder
  import esp_pkg::*;
#(
  parameter int COUNT = 8,
  parameter int SHIFT = 16,
  localparam int IDX_W  = (COUNT > 1) ? $clog2(COUNT) : 1,
  localparam int ADDR_W = SHIFT + 1 + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  output logic              ds_rd_req,
  output logic [IDX_W-1:0]  ds_rd_idx,
  input  logic              ds_rd_ack,
  input  logic              ds_rd_miss,
  input  logic [7:0]        ds_rd_data,
  output logic              ds_wr_en,
  output logic [IDX_W-1:0]  ds_wr_idx,
  output logic [7:0]        ds_wr_data,
  output logic              notify_pulse,
  output logic [IDX_W-1:0]  notify_idx
);
  generate
    if (!(SHIFT == 12 || SHIFT == 16)) begin : g_bad_shift
      $error("esp_mmio_decoder: SHIFT must be 12 or 16");
    end
    if (COUNT < 1) begin : g_bad_count
      $error("esp_mmio_decoder: COUNT must be nonzero");
    end
  endgenerate

  typedef enum logic {ST_IDLE, ST_FETCH} state_e;
  state_e state;

  // decode of the incoming access
  logic [IDX_W-1:0] dec_idx;
  logic             dec_esc, dec_err;
  esp_op_e          dec_op;
  logic [1:0]       dec_set;

  // latched access
  logic [IDX_W-1:0] cur_idx;
  logic             cur_esc;
  esp_op_e          cur_op;
  logic [1:0]       cur_set;

  // update results
  esp_desc_t   upd_desc;
  logic [63:0] upd_rdata;
  logic        upd_err, upd_notify, upd_changed;
  logic        accept, finish;

  esp_addr_decode #(
    .SHIFT(SHIFT), .COUNT(COUNT), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(req_addr), .is_store(req_write), .size(req_size),
    .idx(dec_idx), .esc_page(dec_esc), .op(dec_op),
    .set_val(dec_set), .bad(dec_err)
  );

  esp_state_update u_upd (
    .op(cur_op), .esc_page(cur_esc), .set_val(cur_set),
    .desc(esp_desc_t'(ds_rd_data)), .miss(ds_rd_miss),
    .new_desc(upd_desc), .rdata(upd_rdata), .err(upd_err),
    .notify(upd_notify), .changed(upd_changed)
  );

  assign req_ready = (state == ST_IDLE);
  assign ds_rd_req = (state == ST_FETCH);
  assign ds_rd_idx = cur_idx;
  assign accept    = req_valid && req_ready;
  assign finish    = ds_rd_req && ds_rd_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cur_idx      <= '0;
      cur_esc      <= 1'b0;
      cur_op       <= OP_BAD;
      cur_set      <= '0;
      rsp_valid    <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_rdata    <= '0;
      ds_wr_en     <= 1'b0;
      ds_wr_idx    <= '0;
      ds_wr_data   <= '0;
      notify_pulse <= 1'b0;
      notify_idx   <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      ds_wr_en     <= 1'b0;
      notify_pulse <= 1'b0;
      if (accept) begin
        cur_idx <= dec_idx;
        cur_esc <= dec_esc;
        cur_op  <= dec_op;
        cur_set <= dec_set;
        if (dec_err) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_rdata <= req_write ? '0 : '1;
        end else begin
          state <= ST_FETCH;
        end
      end
      if (finish) begin
        state        <= ST_IDLE;
        rsp_valid    <= 1'b1;
        rsp_err      <= upd_err;
        rsp_rdata    <= upd_rdata;
        ds_wr_en     <= upd_changed;
        ds_wr_idx    <= cur_idx;
        ds_wr_data   <= upd_desc;
        notify_pulse <= upd_notify;
        notify_idx   <= cur_idx;
      end
    end
  end

  // R11
  wb_only_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_wr_en |-> ($past(ds_rd_ack) && ds_wr_data != $past(ds_rd_data)));
  // R11
  wb_clean_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_wr_en |-> (rsp_valid && !rsp_err));
  // R12
  notify_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_pulse |-> (rsp_valid && !rsp_err && notify_idx == ds_rd_idx));
  // R2
  fetch_idx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_rd_req && $past(ds_rd_req)) |-> $stable(ds_rd_idx));
  // R3
  decode_err_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_err) |=> (rsp_valid && rsp_err && !ds_rd_req));
  // R10
  inject_esc_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && cur_op == OP_ST_INJ && cur_esc) |=> (rsp_err && !notify_pulse));
  // R6
  get_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && cur_op == OP_LD_GET) |=> !ds_wr_en);
endmodule

// File: tb/test_esp_mmio_decoder.sv
module test_esp_mmio_decoder;
  localparam int CNT = 6;
  localparam int SH  = 12;
  localparam int IW  = 3;
  localparam int AW  = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [3:0]    req_size;
  logic          rsp_valid, rsp_err;
  logic [63:0]   rsp_rdata;
  logic          ds_rd_req, ds_rd_ack, ds_rd_miss;
  logic [IW-1:0] ds_rd_idx, ds_wr_idx, notify_idx;
  logic [7:0]    ds_rd_data, ds_wr_data;
  logic          ds_wr_en, notify_pulse;

  esp_mmio_decoder #(.COUNT(CNT), .SHIFT(SH)) i_esp_mmio_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ds_rd_req(ds_rd_req), .ds_rd_idx(ds_rd_idx), .ds_rd_ack(ds_rd_ack),
    .ds_rd_miss(ds_rd_miss), .ds_rd_data(ds_rd_data), .ds_wr_en(ds_wr_en),
    .ds_wr_idx(ds_wr_idx), .ds_wr_data(ds_wr_data),
    .notify_pulse(notify_pulse), .notify_idx(notify_idx)
  );

  int checks = 0;
  int errors = 0;

  // descriptor store model: ack one cycle after request
  logic [7:0] init_mem [8];
  logic [7:0] smem [8];
  logic [7:0] miss_m;
  int         rd_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      ds_rd_ack  <= 1'b0;
      ds_rd_miss <= 1'b0;
      ds_rd_data <= '0;
      rd_cnt     <= 0;
      for (int i = 0; i < 8; i++) smem[i] <= init_mem[i];
    end else begin
      if (ds_rd_req && !ds_rd_ack) begin
        ds_rd_ack  <= 1'b1;
        ds_rd_data <= smem[ds_rd_idx];
        ds_rd_miss <= miss_m[ds_rd_idx];
        rd_cnt     <= rd_cnt + 1;
      end else begin
        ds_rd_ack <= 1'b0;
      end
      if (ds_wr_en) smem[ds_wr_idx] <= ds_wr_data;
    end
  end

  typedef struct {
    logic        err;
    logic [63:0] rdata;
    logic        wr;
    logic [7:0]  wdata;
    logic [2:0]  idx;
    logic        ntf;
    logic        fetch;
  } exp_t;

  exp_t  sbq[$];
  string tagq[$];
  logic [7:0] mdl [8];
  int last_cnt = 0;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        exp_t  e;
        string t;
        logic  ok;
        int    dcnt;
        checks++;
        if (sbq.size() == 0) begin
          errors++;
          $display("FAIL R13: unexpected response err=%0b exp none", rsp_err);
        end else begin
          e = sbq.pop_front();
          t = tagq.pop_front();
          dcnt = rd_cnt - last_cnt;
          ok = (rsp_err == e.err) && (rsp_rdata == e.rdata) && (ds_wr_en == e.wr) &&
               (!e.wr || (ds_wr_data == e.wdata && ds_wr_idx == e.idx)) &&
               (notify_pulse == e.ntf) && (!e.ntf || notify_idx == e.idx) &&
               (dcnt == (e.fetch ? 1 : 0));
          if (!ok) begin
            errors++;
            $display("FAIL %s: err=%0b rdata=%h wr=%0b wdata=%h ntf=%0b nidx=%0d reads=%0d exp err=%0b rdata=%h wr=%0b wdata=%h ntf=%0b idx=%0d reads=%0d",
                     t, rsp_err, rsp_rdata, ds_wr_en, ds_wr_data, notify_pulse, notify_idx, dcnt,
                     e.err, e.rdata, e.wr, e.wdata, e.ntf, e.idx, e.fetch ? 1 : 0);
          end
        end
        last_cnt = rd_cnt;
      end else if (ds_wr_en || notify_pulse) begin
        checks++;
        errors++;
        $display("FAIL R11/R12: stray wr=%0b ntf=%0b exp 0 0", ds_wr_en, notify_pulse);
      end
    end
  end

  task automatic chk(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: computes the expectation, pushes it, then performs the access
  task automatic access(input string tag, input logic wr, input int idx,
                        input logic esc, input logic [11:0] off, input logic [3:0] sz);
    exp_t e;
    logic [7:0] d, nd;
    logic [1:0] pq, np;
    logic fire, load;
    e.err = 0; e.rdata = '0; e.wr = 0; e.wdata = '0; e.idx = 3'(idx); e.ntf = 0; e.fetch = 0;
    load = !wr;
    if (sz != 4'd8 || idx >= CNT || (wr && off[11:10] == 2'b11)) begin
      e.err = 1; e.rdata = load ? '1 : '0;
    end else begin
      e.fetch = 1;
      d = mdl[idx];
      if (miss_m[idx] || !d[7]) begin
        e.err = 1; e.rdata = load ? '1 : '0;
      end else begin
        pq = esc ? d[3:2] : d[1:0];
        np = pq; fire = 0;
        if (load && !off[11]) begin
          fire = (pq == 2'b11);
          np = fire ? 2'b10 : (pq == 2'b10 ? 2'b00 : pq);
          e.rdata = {63'd0, fire};
        end else if (load && off[11:10] == 2'b10) begin
          e.rdata = {62'd0, pq};
        end else if (load) begin
          np = off[9:8]; e.rdata = {62'd0, pq};
        end else if (off[11:10] == 2'b00) begin
          fire = (pq == 2'b00);
          np = fire ? 2'b10 : (pq[1] ? 2'b11 : pq);
        end else if (off[11:10] == 2'b01) begin
          fire = (pq == 2'b11);
          np = fire ? 2'b10 : (pq == 2'b10 ? 2'b00 : pq);
        end else if (esc) begin
          e.err = 1;
        end else begin
          fire = 1;
        end
        e.ntf = fire && !e.err;
        nd = d;
        if (esc) nd[3:2] = np; else nd[1:0] = np;
        if (!e.err && np != pq) begin
          e.wr = 1; e.wdata = nd; mdl[idx] = nd;
        end
      end
    end
    sbq.push_back(e);
    tagq.push_back(tag);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {3'(idx), esc, off};
    req_size  = sz;
    @(negedge clk);
    req_valid = 1'b0;
    if (e.fetch)
      chk({tag, " R2/R13 fetch"}, ds_rd_req && ds_rd_idx == 3'(idx) && !req_ready,
          {ds_rd_req, 3'(ds_rd_idx), req_ready}, {1'b1, 3'(idx), 1'b0});
    do @(negedge clk); while (sbq.size() != 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    init_mem[0] = 8'h80; init_mem[1] = 8'h8E; init_mem[2] = 8'h87; init_mem[3] = 8'h03;
    init_mem[4] = 8'h80; init_mem[5] = 8'h85; init_mem[6] = 8'h80; init_mem[7] = 8'h80;
    miss_m = 8'b0001_0000;
    for (int i = 0; i < 8; i++) mdl[i] = init_mem[i];
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = 4'd8;
    repeat (3) @(negedge clk);
    chk("R1 in reset", req_ready && !rsp_valid && !ds_rd_req && !ds_wr_en && !notify_pulse,
        {req_ready, rsp_valid, ds_rd_req, ds_wr_en, notify_pulse}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", req_ready && !rsp_valid && !ds_rd_req && !ds_wr_en && !notify_pulse,
        {req_ready, rsp_valid, ds_rd_req, ds_wr_en, notify_pulse}, 5'b10000);

    access("R6 get notify idx0",        0, 0, 0, 12'h800, 8);
    access("R8 trigger 00->10",         1, 0, 0, 12'h000, 8);
    access("R8 trigger 10->11",         1, 0, 0, 12'h100, 8);
    access("R8 R11 trigger 11 no wb",   1, 0, 0, 12'h3F8, 8);
    access("R5 load eoi 11->10",        0, 0, 0, 12'h000, 8);
    access("R5 load eoi 10->00",        0, 0, 0, 12'h400, 8);
    access("R5 load eoi 00 hold",       0, 0, 0, 12'h7F8, 8);
    access("R8 trigger 01 hold",        1, 5, 0, 12'h000, 8);
    access("R9 store eoi 01 hold",      1, 5, 0, 12'h400, 8);
    access("R9 store eoi 11->10",       1, 2, 0, 12'h7F8, 8);
    access("R7 set esc 11->01",         0, 1, 1, 12'hD00, 8);
    access("R7 R11 set same no wb",     0, 1, 1, 12'hD08, 8);
    access("R6 R2 get esc idx1",        0, 1, 1, 12'hBF8, 8);
    access("R8 trigger esc 01",         1, 1, 1, 12'h200, 8);
    access("R10 inject notify page",    1, 2, 0, 12'h800, 8);
    access("R10 inject escalate page",  1, 1, 1, 12'h900, 8);
    access("R4 invalid descriptor",     0, 3, 0, 12'h800, 8);
    access("R4 missing descriptor",     1, 4, 0, 12'h000, 8);
    access("R3 index out of range",     0, 6, 0, 12'h800, 8);
    access("R3 index 7 store",          1, 7, 1, 12'h000, 8);
    access("R3 store offset 0xC00",     1, 0, 0, 12'hC00, 8);
    access("R3 size 4 load",            0, 0, 0, 12'h800, 4);
    access("R7 R11 set esc 0xF00",      0, 0, 1, 12'hF00, 8);
    access("R5 R12 load eoi esc 11",    0, 0, 1, 12'h7F8, 8);
    access("R2 get esc idx2",           0, 2, 1, 12'h808, 8);
    access("R8 trigger esc idx5",       1, 5, 1, 12'h3F8, 8);
    access("R7 set notify 0xC00",       0, 2, 0, 12'hC00, 8);
    access("R8 R12 trigger idx2",       1, 2, 0, 12'h000, 8);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule